// File: doc/BRIEF.md
# ROM Card Read Sequencer

This block sits on the host side of a 16-bit read-only memory card bus and turns single read requests into properly timed bus cycles. A request carries a byte address and a width flag (one byte or one 16-bit word) and is handed over with a valid/ready handshake. The sequencer drives the card address, two active-low lane enables and an active-low output enable. It waits counted clock cycles until the card's data is guaranteed valid, samples the data lanes and returns the assembled result together with a one-cycle done pulse.

All card timing limits are given in nanoseconds as parameters, together with the clock period. Each limit is rounded up to whole clock cycles. Three limits bound the sampling point: address to data, lane enable to data, and output enable to data. The output enable is held back so that it goes low no earlier than needed. After the sample, the bus is released, and no new access starts before two conditions hold: the card has had time to stop driving the lanes, and the minimum spacing between address changes has passed. A word request at an odd byte address is refused with an error response and no bus activity.

Top module: `card_read_seq`

## Requirements
- R1: After reset the block is idle: `req_ready` is 1, `card_en_lo_n`, `card_en_hi_n` and `card_oe_n` are 1, and `rsp_done` is 0.
- R2: A request is taken at a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the cycle after that edge until the access and its turnaround gap are over. For a good request it rises END-1 cycles after the accepting edge, where END = max(RC, DATA + FLOAT). For an error it rises 1 cycle after that edge.
- R3: A word read (`req_word`=1) pulls both lane enables low. The result holds the even byte from lanes 7:0 in bits 7:0 and the odd byte from lanes 15:8 in bits 15:8.
- R4: A byte read (`req_word`=0) pulls only `card_en_lo_n` low and keeps `card_en_hi_n` high. `card_addr` equals the requested byte address, including bit 0. The byte read from lanes 7:0 is returned in bits 7:0, and bits 15:8 are zero.
- R5: `card_addr` and the lane enables are steady from the accepting edge to the sampling edge. Sampling happens DATA = max(ACC, CE, OE) cycles after the accepting edge. That is at least ACC cycles after the address change and at least CE cycles after the enables went low.
- R6: `card_oe_n` goes low DATA-OE cycles after the accepting edge and stays low for exactly OE cycles up to the sampling edge.
- R7: `rsp_done` is a single-cycle pulse. For a good read it is high in the cycle after the sampling edge, DATA cycles after acceptance. `rsp_data` and `rsp_err` are valid while it is high.
- R8: Once the enables and output enable are released, no lane enable goes low again for at least FLOAT cycles. Two changes of `card_addr` are at least RC cycles apart.
- R9: A word request with byte address bit 0 = 1 produces `rsp_done`=1 with `rsp_err`=1 and `rsp_data`=0 in the cycle after acceptance. No enable and no output enable is asserted for it.
- R10: Each cycle count (RC, ACC, CE, OE, FLOAT) is ceil(limit_ns / CLK_NS), and at least 1. With the defaults these are 34, 34, 34, 15 and 12.
- R11: `card_oe_n` is low only while `card_en_lo_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_addr | input | ADDR_W | Requested byte address |
| req_word | input | 1 | 1: 16-bit word read, 0: single byte read |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_data | output | DATA_W | Assembled read result |
| rsp_err | output | 1 | Request refused (odd word address) |
| card_addr | output | ADDR_W | Byte address driven to the card |
| card_en_lo_n | output | 1 | Active-low enable of the low data lane |
| card_en_hi_n | output | 1 | Active-low enable of the high data lane |
| card_oe_n | output | 1 | Active-low output enable |
| card_data | input | DATA_W | Card data lanes |

## Verification
Two things happen on the same clock edge. The lanes are sampled, and the enables and output enable are released, so one edge both captures the data and frees the bus. The bench card model drives a poison pattern on each lane until every timing limit for that lane is met. It reports a shift of either event by one cycle through a wrong result or a gap violation. A second overlap comes from queueing requests back to back. The bus is reclaimed at the first edge where `req_ready` is high again, which is also the edge where the turnaround gap just expires. The model measures that gap and the spacing between address changes on every access.

// File: rtl/card_seq_pkg.sv
package card_seq_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_ERR    = 2'd1,
    SQ_ACCESS = 2'd2,
    SQ_FLOAT  = 2'd3
  } sq_state_e;

  // Round a nanosecond limit up to whole clock cycles, never below one.
  function automatic int ns_to_cycles(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/card_phase_timer.sv
module card_phase_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             adv_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_nxt_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             cnt_en;

  always_comb begin
    cnt_en    = clr_i | adv_i;
    cnt_nxt_o = cnt_q;
    if (clr_i)      cnt_nxt_o = '0;
    else if (adv_i) cnt_nxt_o = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_nxt_o;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/card_lane_pick.sv
module card_lane_pick #(
  parameter int LANE_W = 8
) (
  input  logic                  word_i,
  input  logic [2*LANE_W-1:0]   lanes_i,
  output logic                  lo_want_o,
  output logic                  hi_want_o,
  output logic [2*LANE_W-1:0]   data_o
);

  // The low lane carries every access; the high lane only word accesses.
  assign lo_want_o = 1'b1;
  assign hi_want_o = word_i;

  for (genvar g = 0; g < 2; g++) begin : g_lane
    if (g == 0) begin : g_low
      assign data_o[LANE_W-1:0] = lanes_i[LANE_W-1:0];
    end else begin : g_high
      assign data_o[2*LANE_W-1:LANE_W] =
        word_i ? lanes_i[2*LANE_W-1:LANE_W] : '0;
    end
  end

endmodule

// File: rtl/card_seq_ctrl.sv
module card_seq_ctrl
  import card_seq_pkg::*;
#(
  parameter int CNT_W     = 6,
  parameter int LAST_ACC  = 33,
  parameter int FLOAT_END = 44
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid_i,
  input  logic             req_bad_i,
  input  logic [CNT_W-1:0] cnt_i,
  output sq_state_e        state_o,
  output sq_state_e        state_nxt_o,
  output logic             accept_o,
  output logic             err_take_o,
  output logic             capture_o,
  output logic             timer_clr_o,
  output logic             timer_adv_o
);

  localparam logic [CNT_W-1:0] LAST_V  = CNT_W'(LAST_ACC);
  localparam logic [CNT_W-1:0] FLOAT_V = CNT_W'(FLOAT_END);

  sq_state_e state_q;

  always_comb begin
    state_nxt_o = state_q;
    accept_o    = 1'b0;
    err_take_o  = 1'b0;
    capture_o   = 1'b0;
    timer_clr_o = 1'b0;
    timer_adv_o = 1'b0;
    case (state_q)
      SQ_IDLE: begin
        if (req_valid_i) begin
          accept_o    = 1'b1;
          timer_clr_o = 1'b1;
          if (req_bad_i) begin
            err_take_o  = 1'b1;
            state_nxt_o = SQ_ERR;
          end else begin
            state_nxt_o = SQ_ACCESS;
          end
        end
      end
      SQ_ACCESS: begin
        timer_adv_o = 1'b1;
        if (cnt_i == LAST_V) begin
          capture_o   = 1'b1;
          state_nxt_o = SQ_FLOAT;
        end
      end
      SQ_FLOAT: begin
        timer_adv_o = 1'b1;
        if (cnt_i >= FLOAT_V) state_nxt_o = SQ_IDLE;
      end
      default: state_nxt_o = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SQ_IDLE;
    else        state_q <= state_nxt_o;
  end

  assign state_o = state_q;

endmodule

// File: rtl/card_read_seq.sv
module card_read_seq
  import card_seq_pkg::*;
#(
  parameter int CLK_NS   = 5,
  parameter int ADDR_W   = 26,
  parameter int DATA_W   = 16,
  parameter int T_RC_NS  = 170,
  parameter int T_ACC_NS = 170,
  parameter int T_CE_NS  = 170,
  parameter int T_OE_NS  = 75,
  parameter int T_DF_NS  = 60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_word,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_err,
  output logic [ADDR_W-1:0] card_addr,
  output logic              card_en_lo_n,
  output logic              card_en_hi_n,
  output logic              card_oe_n,
  input  logic [DATA_W-1:0] card_data
);

  localparam int C_RC   = ns_to_cycles(T_RC_NS,  CLK_NS);
  localparam int C_ACC  = ns_to_cycles(T_ACC_NS, CLK_NS);
  localparam int C_CE   = ns_to_cycles(T_CE_NS,  CLK_NS);
  localparam int C_OE   = ns_to_cycles(T_OE_NS,  CLK_NS);
  localparam int C_DF   = ns_to_cycles(T_DF_NS,  CLK_NS);
  localparam int C_DATA = max2(max2(C_ACC, C_CE), C_OE);
  localparam int OE_AT  = C_DATA - C_OE;
  localparam int C_END  = max2(C_RC, C_DATA + C_DF);
  localparam int CNT_W  = $clog2(C_END + 1);
  localparam int LANE_W = DATA_W / 2;
  localparam logic [CNT_W-1:0] OE_AT_V = CNT_W'(OE_AT);

  sq_state_e         state_q, state_nxt;
  logic              accept, err_take, capture, t_clr, t_adv;
  logic [CNT_W-1:0]  cnt_q, cnt_nxt;
  logic              req_bad;
  logic              word_q, word_sel;
  logic              lo_want, hi_want;
  logic [DATA_W-1:0] picked;
  logic              access_nxt;
  logic              en_lo_d, en_hi_d, oe_d;
  logic              en_lo_q, en_hi_q, oe_q, done_q, err_q;
  logic [DATA_W-1:0] data_q;
  logic [ADDR_W-1:0] addr_q;
  logic              load_req, load_rsp;

  assign req_bad   = req_word & req_addr[0];
  assign req_ready = (state_q == SQ_IDLE);

  card_seq_ctrl #(
    .CNT_W     (CNT_W),
    .LAST_ACC  (C_DATA - 1),
    .FLOAT_END (C_END - 2)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_i (req_valid),
    .req_bad_i   (req_bad),
    .cnt_i       (cnt_q),
    .state_o     (state_q),
    .state_nxt_o (state_nxt),
    .accept_o    (accept),
    .err_take_o  (err_take),
    .capture_o   (capture),
    .timer_clr_o (t_clr),
    .timer_adv_o (t_adv)
  );

  card_phase_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (t_clr),
    .adv_i     (t_adv),
    .cnt_o     (cnt_q),
    .cnt_nxt_o (cnt_nxt)
  );

  // During the accepting cycle the width comes straight from the request.
  assign word_sel = accept ? req_word : word_q;

  card_lane_pick #(
    .LANE_W (LANE_W)
  ) u_lanes (
    .word_i    (word_sel),
    .lanes_i   (card_data),
    .lo_want_o (lo_want),
    .hi_want_o (hi_want),
    .data_o    (picked)
  );

  // Bus controls are registered from the next state, so they change on
  // the same edge as the state and never glitch.
  always_comb begin
    access_nxt = (state_nxt == SQ_ACCESS);
    en_lo_d    = ~(access_nxt & lo_want);
    en_hi_d    = ~(access_nxt & hi_want);
    oe_d       = ~(access_nxt && (cnt_nxt >= OE_AT_V));
    load_req   = accept & ~req_bad;
    load_rsp   = capture | err_take;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_lo_q <= 1'b1;
      en_hi_q <= 1'b1;
      oe_q    <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      en_lo_q <= en_lo_d;
      en_hi_q <= en_hi_d;
      oe_q    <= oe_d;
      done_q  <= load_rsp;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      word_q <= 1'b0;
    end else if (load_req) begin
      addr_q <= req_addr;
      word_q <= req_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      err_q  <= 1'b0;
    end else if (load_rsp) begin
      data_q <= err_take ? '0 : picked;
      err_q  <= err_take;
    end
  end

  assign card_addr    = addr_q;
  assign card_en_lo_n = en_lo_q;
  assign card_en_hi_n = en_hi_q;
  assign card_oe_n    = oe_q;
  assign rsp_done     = done_q;
  assign rsp_data     = data_q;
  assign rsp_err      = err_q;

endmodule

// File: rtl/card_read_seq_chk.sv
module card_read_seq_chk
  import card_seq_pkg::*;
#(
  parameter int CLK_NS  = 5,
  parameter int ADDR_W  = 26,
  parameter int T_OE_NS = 75,
  parameter int T_DF_NS = 60
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_done,
  input logic              rsp_err,
  input logic [ADDR_W-1:0] card_addr,
  input logic              card_en_lo_n,
  input logic              card_en_hi_n,
  input logic              card_oe_n
);

  localparam int C_OE = ns_to_cycles(T_OE_NS, CLK_NS);
  localparam int C_DF = ns_to_cycles(T_DF_NS, CLK_NS);
  localparam int GW   = $clog2(C_DF + 1) + 1;
  localparam int OW   = $clog2(C_OE + 1) + 1;

  logic [GW-1:0] gap_q;
  logic [OW-1:0] oe_run_q;

  // Cycles since the low enable was last released, saturating.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  gap_q <= GW'(C_DF);
    else if (!card_en_lo_n)      gap_q <= '0;
    else if (gap_q < GW'(C_DF))  gap_q <= gap_q + 1'b1;
  end

  // Length of the current output-enable low run, saturating.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     oe_run_q <= '0;
    else if (card_oe_n)             oe_run_q <= '0;
    else if (oe_run_q < OW'(C_OE))  oe_run_q <= oe_run_q + 1'b1;
  end

  a_r11_oe_inside_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !card_oe_n |-> !card_en_lo_n);

  a_r3_high_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
    !card_en_hi_n |-> !card_en_lo_n);

  a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !card_en_lo_n |-> !req_ready);

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  a_r9_err_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && rsp_err) |-> (card_en_lo_n && card_en_hi_n && card_oe_n));

  a_r5_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!card_en_lo_n && $past(!card_en_lo_n)) |-> $stable(card_addr));

  a_r8_float_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(card_en_lo_n) |-> (gap_q >= GW'(C_DF)));

  a_r6_oe_window: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && !rsp_err) |-> (oe_run_q == OW'(C_OE)));

endmodule

bind card_read_seq card_read_seq_chk #(
  .CLK_NS  (CLK_NS),
  .ADDR_W  (ADDR_W),
  .T_OE_NS (T_OE_NS),
  .T_DF_NS (T_DF_NS)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_ready    (req_ready),
  .rsp_done     (rsp_done),
  .rsp_err      (rsp_err),
  .card_addr    (card_addr),
  .card_en_lo_n (card_en_lo_n),
  .card_en_hi_n (card_en_hi_n),
  .card_oe_n    (card_oe_n)
);

// File: tb/tb_card_read_seq.sv
`timescale 1ns/1ps
module tb_card_read_seq;

  localparam int AW     = 26;
  localparam int DW     = 16;
  // R10: expected cycle counts at 5 ns: ceil(170/5), ceil(75/5), ceil(60/5)
  localparam int E_ACC  = 34;
  localparam int E_CE   = 34;
  localparam int E_OE   = 15;
  localparam int E_DF   = 12;
  localparam int E_RC   = 34;
  localparam int E_DATA = 34;
  localparam int E_END  = 46;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic          req_ready;
  logic [AW-1:0] req_addr;
  logic          req_word;
  logic          rsp_done;
  logic [DW-1:0] rsp_data;
  logic          rsp_err;
  logic [AW-1:0] card_addr;
  logic          card_en_lo_n, card_en_hi_n, card_oe_n;
  logic [DW-1:0] card_data;

  always #2.5 clk = ~clk;

  card_read_seq dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_word(req_word),
    .rsp_done(rsp_done), .rsp_data(rsp_data), .rsp_err(rsp_err),
    .card_addr(card_addr), .card_en_lo_n(card_en_lo_n),
    .card_en_hi_n(card_en_hi_n), .card_oe_n(card_oe_n),
    .card_data(card_data)
  );

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit all_done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] rom_byte(input logic [AW-1:0] a);
    logic [7:0] m;
    m = 8'(a[7:0] * 8'd37);
    return m ^ a[15:8] ^ a[23:16] ^ 8'hA5;
  endfunction

  always @(posedge clk) cyc++;

  // ---------------- card model ----------------
  logic [AW-1:0] prev_addr = '0;
  bit  prev_lo = 1'b1, prev_hi = 1'b1, prev_oe = 1'b1;
  bit  addr_seen = 1'b0;
  bit  hi_seen = 1'b0;
  int  addr_age = 0, lo_age = 0, hi_age = 0, oe_age = 0;
  int  since_chg = 0, rel_age = 1000, r11_bad = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (card_addr !== prev_addr) begin
        if (addr_seen)
          chk(since_chg >= E_RC, "R8", "address change spacing", since_chg, E_RC);
        addr_seen = 1'b1;
        since_chg = 0;
        addr_age  = 0;
      end else begin
        since_chg++;
        addr_age++;
      end
      if (!card_en_lo_n) begin
        if (prev_lo) begin
          chk(rel_age >= E_DF, "R8", "float gap before enable", rel_age, E_DF);
          lo_age  = 0;
          hi_seen = 1'b0;
        end else lo_age++;
      end
      if (!card_en_hi_n) begin
        if (prev_hi) hi_age = 0; else hi_age++;
        hi_seen = 1'b1;
      end
      if (!card_oe_n) begin
        if (prev_oe) oe_age = 0; else oe_age++;
      end
      if (card_en_lo_n && card_en_hi_n && card_oe_n && (!prev_lo || !prev_oe))
        rel_age = 0;
      else
        rel_age++;
      if (!card_oe_n && card_en_lo_n) r11_bad++;
    end
    prev_addr = card_addr;
    prev_lo   = card_en_lo_n;
    prev_hi   = card_en_hi_n;
    prev_oe   = card_oe_n;
    // Lanes carry poison until every limit of the lane is met at the next edge.
    if (!card_en_lo_n && !card_oe_n && addr_age + 1 >= E_ACC &&
        lo_age + 1 >= E_CE && oe_age + 1 >= E_OE)
      card_data[7:0] = rom_byte(card_en_hi_n ? card_addr : {card_addr[AW-1:1], 1'b0});
    else
      card_data[7:0] = 8'hEE;
    if (!card_en_hi_n && !card_oe_n && addr_age + 1 >= E_ACC &&
        hi_age + 1 >= E_CE && oe_age + 1 >= E_OE)
      card_data[15:8] = rom_byte({card_addr[AW-1:1], 1'b1});
    else
      card_data[15:8] = 8'h99;
  end

  // ---------------- scoreboard ----------------
  typedef struct {
    logic [DW-1:0] data;
    logic          err;
    logic          word;
    logic [AW-1:0] addr;
    int            acc;
  } exp_t;

  exp_t exp_q[$];

  task automatic issue(input logic [AW-1:0] a, input logic w);
    exp_t e;
    int   acc;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    req_word  = w;
    @(posedge clk);
    #1;
    acc       = cyc;
    req_valid = 1'b0;
    e.err  = w & a[0];
    e.word = w;
    e.addr = a;
    e.acc  = acc;
    if (e.err)  e.data = '0;
    else if (w) e.data = {rom_byte({a[AW-1:1], 1'b1}), rom_byte(a)};
    else        e.data = {8'h00, rom_byte(a)};
    exp_q.push_back(e);
    @(negedge clk);
    chk(!req_ready, "R2", "ready low after accept", req_ready, 0);
    while (!req_ready) @(negedge clk);
    chk((cyc - acc) == (e.err ? 1 : E_END - 1), "R2", "ready return cycle",
        cyc - acc, e.err ? 1 : E_END - 1);
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_done) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7", "unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (e.err) begin
          chk(rsp_err == 1'b1, "R9", "error flag", rsp_err, 1);
          chk(rsp_data == '0, "R9", "error data", rsp_data, 0);
          chk((cyc - e.acc) == 0, "R9", "error latency", cyc - e.acc, 0);
        end else begin
          chk(rsp_err == 1'b0, e.word ? "R3" : "R4", "no error", rsp_err, 0);
          chk(rsp_data == e.data, e.word ? "R3" : "R4", "read data (R5 R6)",
              rsp_data, e.data);
          chk((cyc - e.acc) == E_DATA, "R7", "done latency (R10)",
              cyc - e.acc, E_DATA);
          chk(hi_seen == e.word, e.word ? "R3" : "R4", "high enable use",
              hi_seen, e.word);
          chk(card_addr == e.addr, "R4", "card address incl. bit 0",
              card_addr, e.addr);
        end
      end
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_addr  = '0;
    req_word  = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(req_ready == 1'b1, "R1", "reset ready", req_ready, 1);
    chk(card_en_lo_n == 1'b1, "R1", "reset low enable", card_en_lo_n, 1);
    chk(card_en_hi_n == 1'b1, "R1", "reset high enable", card_en_hi_n, 1);
    chk(card_oe_n == 1'b1, "R1", "reset output enable", card_oe_n, 1);
    chk(rsp_done == 1'b0, "R1", "reset done", rsp_done, 0);

    issue(26'h0000100, 1'b1);   // word, low address
    issue(26'h3FFFFFE, 1'b1);   // word, top of range
    issue(26'h0000201, 1'b0);   // byte, odd parity
    issue(26'h0000200, 1'b0);   // byte, even parity
    issue(26'h0000333, 1'b1);   // odd word: refused
    issue(26'h0000333, 1'b0);   // same address as a byte
    issue(26'h1ABCDE4, 1'b1);
    issue(26'h0000001, 1'b1);   // second refusal in a row
    issue(26'h0000001, 1'b1);
    issue(26'h2F0F0F1, 1'b0);
    issue(26'h0000000, 1'b1);

    repeat (60) @(negedge clk);
    chk(exp_q.size() == 0, "R7", "all responses seen", exp_q.size(), 0);
    chk(r11_bad == 0, "R11", "output enable without lane enable", r11_bad, 0);
    all_done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!all_done) begin
      total++;
      bad++;
      $display("FAIL watchdog R2: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule